// File: doc/BRIEF.md
# Pipelined Backend Write Strobe Generator

This block sits between the target-side data-phase control of a 64-bit PCI interface and a backend memory port. On every clock where a write data phase is in progress, the backend signals that it can take data and the bus initiator has IRDY# asserted, the block issues a one-cycle address increment. It also issues per-byte write strobes for the low and high 32-bit halves of the data bus. The strobes are the active-low PCI byte enables inverted.

Some backends return or capture data a fixed number of cycles after the address, as a synchronous SRAM does. For these, a 3-bit pipeline count is sampled when a new data-phase sequence starts. That many qualified cycles then advance the address with the strobes held low, and a masked indicator is raised while the count is non-zero. A count of zero makes address and data coincident. Every output is registered, so each output reflects the inputs of the previous clock.

Top module: `be_wr_strobe`

## Requirements
- R1: A write strobe bit is high only in the cycle after a qualified cycle: `phase_act` high, `be_rdy` high and `irdy_n` low.
- R2: On an unmasked qualified cycle, `wr_lo[i]` equals the inverse of `cbe_n[i]` and `wr_hi[i]` equals the inverse of `cbe_n[4+i]` for i = 0..3, one cycle later.
- R3: When `pipe_cnt` is 0 at the start of a sequence, the first qualified cycle already produces strobes.
- R4: When `pipe_cnt` is N (1..7) at the start of a sequence, the first N qualified cycles produce `addr_inc` with all strobes low. Strobes follow from cycle N+1 on.
- R5: Cycles that are not qualified do not consume the latency count.
- R6: `addr_inc` is high exactly one cycle after each qualified cycle, whether that cycle is masked or not.
- R7: `masked` is high one cycle after any cycle with `phase_act` high and latency remaining. While `masked` is high, all strobes are low.
- R8: A rising edge of `phase_act` starts a new sequence and reloads the count from `pipe_cnt`. Any count left over from the previous sequence is discarded.
- R9: Synchronous active-high `rst` forces all outputs low on the following clock and clears the latency count.
- R10: When `phase_act` is low, the next cycle has `addr_inc`, `masked` and all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous reset, active high |
| irdy_n | input | 1 | Bus initiator ready, active low |
| be_rdy | input | 1 | Backend ready to accept data |
| pipe_cnt | input | 3 | Backend pipeline latency in qualified cycles |
| phase_act | input | 1 | Write data phase in progress |
| cbe_n | input | 8 | PCI byte enables, active low, bit i = byte i |
| wr_lo | output | 4 | Write strobes for bytes 0..3 |
| wr_hi | output | 4 | Write strobes for bytes 4..7 |
| addr_inc | output | 1 | Advance backend address |
| masked | output | 1 | Latency window in effect |

## Verification
The bench targets stalls inside a latency window. A design that decremented on every clock would release strobes too early, with data landing at the wrong address. It drives the maximum count of 7 and a count of 0. An off-by-one in the load or compare shows up there as one strobe too many or too few. It also drops and re-raises `phase_act` mid-window. A design that kept the stale count instead of reloading would mask the wrong cycles. Random lane patterns on the byte enables catch swapped halves or missing inversion, and resets in mid-sequence catch a counter that survives reset.

// File: rtl/be_wr_pkg.sv
package be_wr_pkg;
  localparam int unsigned LANES_PER_GRP = 4;
  localparam int unsigned LAT_W_DEF     = 3;
  localparam int unsigned LANES_DEF     = 8;
endpackage

// File: rtl/be_wr_qualify.sv
module be_wr_qualify (
  input  logic clk,
  input  logic rst,
  input  logic phase_act,
  input  logic be_rdy,
  input  logic irdy_n,
  output logic qual,
  output logic seq_start
);
  logic act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= phase_act;
  end

  assign qual      = phase_act & be_rdy & ~irdy_n;
  assign seq_start = phase_act & ~act_q;

  AST_START_ONCE: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start); // R8
endmodule

// File: rtl/be_wr_latency.sv
module be_wr_latency #(
  parameter int unsigned LAT_W = be_wr_pkg::LAT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_act,
  input  logic             qual,
  input  logic             seq_start,
  input  logic [LAT_W-1:0] load_val,
  output logic             hold_off
);
  logic [LAT_W-1:0] cnt_q;
  logic [LAT_W-1:0] cnt_eff;

  assign cnt_eff  = seq_start ? load_val : cnt_q;
  assign hold_off = phase_act && (cnt_eff != '0);

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (!phase_act)         cnt_q <= '0;
    else if (qual && hold_off)   cnt_q <= cnt_eff - LAT_W'(1);
    else                         cnt_q <= cnt_eff;
  end

  AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (phase_act && !qual && !seq_start) |=> $stable(cnt_q)); // R5
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (qual && hold_off && !seq_start) |=> (cnt_q < $past(cnt_q))); // R4
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !phase_act |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/be_wr_outreg.sv
module be_wr_outreg #(
  parameter int unsigned LANES = be_wr_pkg::LANES_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qual,
  input  logic             hold_off,
  input  logic [LANES-1:0] cbe_n,
  output logic [LANES-1:0] stb,
  output logic             inc,
  output logic             msk
);
  localparam int unsigned NGRP = LANES / be_wr_pkg::LANES_PER_GRP;

  logic [LANES-1:0] stb_d;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned LO = g * be_wr_pkg::LANES_PER_GRP;
    assign stb_d[LO +: be_wr_pkg::LANES_PER_GRP] =
      (qual && !hold_off) ? ~cbe_n[LO +: be_wr_pkg::LANES_PER_GRP] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb <= '0;
      inc <= 1'b0;
      msk <= 1'b0;
    end else begin
      stb <= stb_d;
      inc <= qual;
      msk <= hold_off;
    end
  end

  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (rst)
    msk |-> (stb == '0)); // R7
  AST_STB_WITH_INC: assert property (@(posedge clk) disable iff (rst)
    (stb != '0) |-> inc); // R6
endmodule

// File: rtl/be_wr_strobe.sv
module be_wr_strobe #(
  parameter int unsigned LAT_W = be_wr_pkg::LAT_W_DEF,
  parameter int unsigned LANES = be_wr_pkg::LANES_DEF,
  localparam int unsigned HALF = LANES / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irdy_n,
  input  logic             be_rdy,
  input  logic [LAT_W-1:0] pipe_cnt,
  input  logic             phase_act,
  input  logic [LANES-1:0] cbe_n,
  output logic [HALF-1:0]  wr_lo,
  output logic [HALF-1:0]  wr_hi,
  output logic             addr_inc,
  output logic             masked
);
  logic             qual;
  logic             seq_start;
  logic             hold_off;
  logic [LANES-1:0] stb;

  be_wr_qualify i_qualify (
    .clk(clk), .rst(rst), .phase_act(phase_act), .be_rdy(be_rdy),
    .irdy_n(irdy_n), .qual(qual), .seq_start(seq_start)
  );

  be_wr_latency #(.LAT_W(LAT_W)) i_latency (
    .clk(clk), .rst(rst), .phase_act(phase_act), .qual(qual),
    .seq_start(seq_start), .load_val(pipe_cnt), .hold_off(hold_off)
  );

  be_wr_outreg #(.LANES(LANES)) i_outreg (
    .clk(clk), .rst(rst), .qual(qual), .hold_off(hold_off), .cbe_n(cbe_n),
    .stb(stb), .inc(addr_inc), .msk(masked)
  );

  assign wr_lo = stb[HALF-1:0];
  assign wr_hi = stb[LANES-1:HALF];

  AST_STB_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    ((wr_lo != '0) || (wr_hi != '0)) |-> $past(be_rdy && !irdy_n)); // R1
  AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    !phase_act |=> (!addr_inc && !masked && wr_lo == '0 && wr_hi == '0)); // R10
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!addr_inc && !masked && wr_lo == '0 && wr_hi == '0)); // R9
endmodule

// File: tb/test_be_wr_strobe.sv
module test_be_wr_strobe;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       irdy_n = 1'b1;
  logic       be_rdy = 1'b0;
  logic [2:0] pipe_cnt = '0;
  logic       phase_act = 1'b0;
  logic [7:0] cbe_n = 8'hFF;
  logic [3:0] wr_lo, wr_hi;
  logic       addr_inc, masked;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [2:0] m_cnt = '0;
  logic       m_prev = 1'b0;
  logic [3:0] e_lo = '0, e_hi = '0;
  logic       e_inc = 1'b0, e_msk = 1'b0;
  string      stb_tag = "R9", inc_tag = "R9", msk_tag = "R9";

  always #5 clk = ~clk;

  be_wr_strobe i_be_wr_strobe (
    .clk(clk), .rst(rst), .irdy_n(irdy_n), .be_rdy(be_rdy),
    .pipe_cnt(pipe_cnt), .phase_act(phase_act), .cbe_n(cbe_n),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .addr_inc(addr_inc), .masked(masked)
  );

  function automatic logic [2:0] eff_cnt(logic act, logic prev, logic [2:0] pc, logic [2:0] c);
    return (act && !prev) ? pc : c;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_out();
    chk({stb_tag, " wr_lo"}, {4'h0, wr_lo}, {4'h0, e_lo});
    chk({stb_tag, " wr_hi"}, {4'h0, wr_hi}, {4'h0, e_hi});
    chk({inc_tag, " addr_inc"}, {7'h0, addr_inc}, {7'h0, e_inc});
    chk({msk_tag, " masked"}, {7'h0, masked}, {7'h0, e_msk});
  endtask

  // Predict outputs for the inputs just applied (seen at the next edge).
  task automatic predict();
    logic [2:0] eff;
    logic q;
    if (rst) begin
      e_lo = '0; e_hi = '0; e_inc = 0; e_msk = 0; m_cnt = '0; m_prev = 0;
      stb_tag = "R9"; inc_tag = "R9"; msk_tag = "R9";
      return;
    end
    eff = eff_cnt(phase_act, m_prev, pipe_cnt, m_cnt);
    q = phase_act && be_rdy && !irdy_n;
    e_inc = q;
    e_msk = phase_act && (eff != 0);
    e_lo = (q && eff == 0) ? ~cbe_n[3:0] : 4'h0;
    e_hi = (q && eff == 0) ? ~cbe_n[7:4] : 4'h0;
    stb_tag = !q ? "R1" : (eff != 0) ? "R4" : (phase_act && !m_prev) ? "R3" : "R2";
    inc_tag = phase_act ? "R6" : "R10";
    msk_tag = (phase_act && !m_prev) ? "R8" : phase_act ? "R7" : "R10";
    if (!phase_act)          m_cnt = '0;
    else if (q && eff != 0)  m_cnt = eff - 3'd1;
    else                     m_cnt = eff;
    m_prev = phase_act;
  endtask

  task automatic step(logic r, logic act, logic rdy, logic irn, logic [2:0] pc, logic [7:0] be);
    @(negedge clk);
    check_out();
    rst = r; phase_act = act; be_rdy = rdy; irdy_n = irn; pipe_cnt = pc; cbe_n = be;
    predict();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R9: reset state, with activity on inputs
    step(1, 1, 1, 0, 3'd0, 8'h00);
    step(1, 1, 1, 0, 3'd0, 8'h00);
    step(0, 0, 0, 1, 3'd0, 8'hFF);
    // R3: count zero, strobes immediately; R2 lane mapping
    step(0, 1, 1, 0, 3'd0, 8'hA5);
    step(0, 1, 1, 0, 3'd5, 8'h3C);
    step(0, 0, 0, 1, 3'd0, 8'hFF);
    // R4: count 2 with R5 stalls inside the window
    step(0, 1, 1, 0, 3'd2, 8'h00);
    step(0, 1, 0, 0, 3'd0, 8'h00);
    step(0, 1, 1, 1, 3'd0, 8'h00);
    step(0, 1, 1, 0, 3'd0, 8'h0F);
    step(0, 1, 1, 0, 3'd0, 8'hF0);
    step(0, 1, 1, 0, 3'd0, 8'h5A);
    // R8: drop mid-window and reload
    step(0, 0, 1, 0, 3'd0, 8'hFF);
    step(0, 1, 1, 0, 3'd7, 8'h00);
    step(0, 1, 1, 0, 3'd0, 8'h00);
    step(0, 0, 1, 0, 3'd0, 8'h00);
    step(0, 1, 1, 0, 3'd1, 8'h11);
    step(0, 1, 1, 0, 3'd0, 8'h22);
    // maximum count 7, all qualified
    step(0, 0, 0, 1, 3'd0, 8'hFF);
    for (int k = 0; k < 10; k++) step(0, 1, 1, 0, (k == 0) ? 3'd7 : 3'd0, 8'(k * 37));
    // R9: reset mid-window
    step(0, 0, 0, 1, 3'd0, 8'hFF);
    step(0, 1, 1, 0, 3'd4, 8'h00);
    step(1, 1, 1, 0, 3'd0, 8'h00);
    step(0, 1, 1, 0, 3'd0, 8'h99);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic act;
      act = (n % 23 == 0) ? 1'b0 : (($urandom % 100) < 88);
      step((($urandom % 500) == 0), act, (($urandom % 4) != 0), (($urandom % 4) == 0),
           3'($urandom), 8'($urandom));
    end
    step(0, 0, 0, 1, 3'd0, 8'hFF);
    @(negedge clk);
    check_out();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule